// File: doc/BRIEF.md
# Accumulator CPU with Two-Word Instruction Fetch

This block is a compact accumulator processor core. All of its datapath registers, together with its control sequencer, change state on the falling edge of the clock. The core fetches every instruction as two 16-bit words from a word-addressed synchronous memory that has a fixed read latency of one cycle. The first word goes into the upper half of a 32-bit instruction register and the second word into the lower half. The upper 8 bits of the instruction register are the opcode. The lower 24 bits are an operand address, which may be steered into the memory address register, the program counter or the stack pointer.

Every memory access goes through the address register and the buffer register. A read returns the addressed word into the buffer register. A write stores the buffer register at the addressed location. The accumulator works with a small ALU that adds, ANDs and ORs the accumulator with the buffer register. The ALU reports carry, overflow, negative and zero flags. The memory port is a plain strobe interface with fixed timing, so it has no valid/ready handshake and no back-pressure. Debug outputs expose the architectural registers so that a surrounding environment can watch execution.

Top module: `acc_cpu_core`

## Requirements
- R1: While rst_n is low, PC, AC and all flags are 0, SP is 0xFFFFFF, halted is 0, and both memory strobes are low.
- R2: Each instruction is fetched by two reads, one at PC and one at PC+1. The first word supplies opcode[7:0] and address[23:16] (word bits 15:8 and 7:0). The second word supplies address[15:0]. PC advances by one on the falling edge that ends each read cycle. mem_rd and mem_wr are never high together.
- R3: Opcode 0x01 loads AC from the word at the address field. N becomes AC bit 15, Z becomes (AC==0), and C and V are cleared. Flags appear on dbg_flags as {C,V,N,Z} in bits 3..0.
- R4: Opcode 0x03 adds the word at the address field to AC. C is the carry out of bit 15. V is set when both operands have the same sign and the sum has the other sign. N and Z follow the result.
- R5: Opcode 0x04 ANDs and opcode 0x05 ORs the word at the address field into AC. N and Z follow the result, and C and V are cleared.
- R6: Opcode 0x02 writes AC to the address field in exactly one mem_wr cycle, with mem_wdata equal to AC. AC and the flags are left unchanged.
- R7: Opcode 0x06 loads PC with the address field. Opcode 0x07 does the same only when Z is 1 and otherwise continues at the next instruction. Neither changes the flags.
- R8: Opcode 0x08 writes AC at SP and then decrements SP. Opcode 0x09 increments SP and then loads AC from the word at the new SP, with flags set as for a load. Opcode 0x0A loads SP with the address field.
- R9: Opcode 0x00 raises halted. From then on halted stays high, PC is stable, and no memory strobe is issued until reset.
- R10: Any other opcode changes nothing except the PC, which advances by 2.
- R11: Counted in falling edges from the start of the fetch, an instruction takes 8 cycles for halt, jumps, SP load and no-ops. It takes 9 for store and push, 11 for load, add, AND and OR, and 12 for pop.
- R12: PC, SP, AC, flags and the memory address change only on falling clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 24 | Word address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data is returned one cycle later |
| mem_wr | output | 1 | Write strobe for the word on mem_wdata |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rdata | input | 16 | Read data, valid in the cycle after mem_rd |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_pc | output | 24 | Program counter |
| dbg_sp | output | 24 | Stack pointer |
| dbg_ac | output | 16 | Accumulator |
| dbg_flags | output | 4 | Flags {C,V,N,Z} |
| dbg_ir | output | 32 | Instruction register |

## Verification
The assertions check four things on every clock: the two strobes are exclusive, write data equals the accumulator whenever a write happens, N and Z agree with the accumulator after each ALU write-back, and the halt state holds with PC frozen and no strobes. They also check that the stack pointer never receives two operations at once. Only the bench's program can show the rest. That covers the arithmetic and flag values, the taken and not-taken conditional jumps, the push/pop ordering in memory, the no-op behaviour of unknown opcodes, and the exact instruction lengths in cycles. A behavioural interpreter predicts all of these at each instruction boundary.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_HALT  = 8'h00;
  localparam int OP_LOAD  = 8'h01;
  localparam int OP_STORE = 8'h02;
  localparam int OP_ADD   = 8'h03;
  localparam int OP_AND   = 8'h04;
  localparam int OP_OR    = 8'h05;
  localparam int OP_JMP   = 8'h06;
  localparam int OP_JZ    = 8'h07;
  localparam int OP_PUSH  = 8'h08;
  localparam int OP_POP   = 8'h09;
  localparam int OP_LDSP  = 8'h0A;

  typedef enum logic [3:0] {
    ST_F1_ADDR, ST_F1_RD, ST_F1_CAP, ST_F1_IR,
    ST_F2_RD, ST_F2_CAP, ST_F2_IR, ST_DECODE,
    ST_EX_POP, ST_EX_RD, ST_EX_CAP, ST_EX_ALU,
    ST_EX_WR, ST_HALT
  } cu_state_e;

  typedef enum logic [1:0] {
    ALU_PASS, ALU_ADD, ALU_AND, ALU_OR
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic n;
    logic z;
  } flags_t;

  typedef struct packed {
    logic    mar_from_pc;
    logic    mar_from_ir;
    logic    mar_from_sp;
    logic    mbr_from_mem;
    logic    mbr_from_ac;
    logic    ir_hi_ld;
    logic    ir_lo_ld;
    logic    pc_en;
    logic    pc_inc;
    logic    sp_inc;
    logic    sp_dec;
    logic    sp_ld;
    logic    ac_ld;
    logic    mem_rd;
    logic    mem_wr;
    alu_op_e alu_op;
  } ctl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output flags_t       flags_o
);
  logic [W:0]   sum_w;
  logic [W-1:0] res_w;
  logic         c_w, v_w;

  assign sum_w = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    res_w = b_i;
    c_w   = 1'b0;
    v_w   = 1'b0;
    unique case (op_i)
      ALU_ADD: begin
        res_w = sum_w[W-1:0];
        c_w   = sum_w[W];
        v_w   = (a_i[W-1] == b_i[W-1]) && (sum_w[W-1] != a_i[W-1]);
      end
      ALU_AND: res_w = a_i & b_i;
      ALU_OR:  res_w = a_i | b_i;
      default: res_w = b_i;
    endcase
  end

  assign res_o     = res_w;
  assign flags_o.c = c_w;
  assign flags_o.v = v_w;
  assign flags_o.n = res_w[W-1];
  assign flags_o.z = (res_w == '0);
endmodule

// File: rtl/acc_pc_reg.sv
module acc_pc_reg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         inc_sel_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] pc_o
);
  logic [W-1:0] pc_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (en_i) begin
      if (inc_sel_i) pc_q <= pc_q + W'(1);
      else           pc_q <= load_i;
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/acc_sp_reg.sv
module acc_sp_reg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         ld_i,
  input  logic [W-1:0] load_i,
  output logic [W-1:0] sp_o
);
  logic [W-1:0] sp_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '1;
    else if (ld_i)  sp_q <= load_i;
    else if (inc_i) sp_q <= sp_q + W'(1);
    else if (dec_i) sp_q <= sp_q - W'(1);
  end

  assign sp_o = sp_q;

  assert_sp_single_op_R8: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0({inc_i, dec_i, ld_i}));
endmodule

// File: rtl/acc_ctrl_unit.sv
module acc_ctrl_unit
  import acc_cpu_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             flag_z_i,
  output ctl_t             ctl_o,
  output logic             halted_o
);
  cu_state_e state_q, state_d;
  ctl_t      ctl;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_F1_ADDR;
    else        state_q <= state_d;
  end

  always_comb begin
    ctl     = '0;
    state_d = state_q;
    unique case (state_q)
      ST_F1_ADDR: begin ctl.mar_from_pc = 1'b1; state_d = ST_F1_RD; end
      ST_F1_RD: begin
        ctl.mem_rd = 1'b1; ctl.pc_en = 1'b1; ctl.pc_inc = 1'b1;
        state_d = ST_F1_CAP;
      end
      ST_F1_CAP: begin ctl.mbr_from_mem = 1'b1; state_d = ST_F1_IR; end
      ST_F1_IR: begin
        ctl.ir_hi_ld = 1'b1; ctl.mar_from_pc = 1'b1;
        state_d = ST_F2_RD;
      end
      ST_F2_RD: begin
        ctl.mem_rd = 1'b1; ctl.pc_en = 1'b1; ctl.pc_inc = 1'b1;
        state_d = ST_F2_CAP;
      end
      ST_F2_CAP: begin ctl.mbr_from_mem = 1'b1; state_d = ST_F2_IR; end
      ST_F2_IR:  begin ctl.ir_lo_ld = 1'b1; state_d = ST_DECODE; end
      ST_DECODE: begin
        state_d = ST_F1_ADDR;
        case (opcode_i)
          OPC_W'(OP_HALT): state_d = ST_HALT;
          OPC_W'(OP_LOAD), OPC_W'(OP_ADD), OPC_W'(OP_AND), OPC_W'(OP_OR): begin
            ctl.mar_from_ir = 1'b1;
            state_d = ST_EX_RD;
          end
          OPC_W'(OP_STORE): begin
            ctl.mar_from_ir = 1'b1; ctl.mbr_from_ac = 1'b1;
            state_d = ST_EX_WR;
          end
          OPC_W'(OP_JMP): ctl.pc_en = 1'b1;
          OPC_W'(OP_JZ):  ctl.pc_en = flag_z_i;
          OPC_W'(OP_PUSH): begin
            ctl.mar_from_sp = 1'b1; ctl.mbr_from_ac = 1'b1; ctl.sp_dec = 1'b1;
            state_d = ST_EX_WR;
          end
          OPC_W'(OP_POP): begin ctl.sp_inc = 1'b1; state_d = ST_EX_POP; end
          OPC_W'(OP_LDSP): ctl.sp_ld = 1'b1;
          default: state_d = ST_F1_ADDR;
        endcase
      end
      ST_EX_POP: begin ctl.mar_from_sp = 1'b1; state_d = ST_EX_RD; end
      ST_EX_RD:  begin ctl.mem_rd = 1'b1; state_d = ST_EX_CAP; end
      ST_EX_CAP: begin ctl.mbr_from_mem = 1'b1; state_d = ST_EX_ALU; end
      ST_EX_ALU: begin
        ctl.ac_ld = 1'b1;
        case (opcode_i)
          OPC_W'(OP_ADD): ctl.alu_op = ALU_ADD;
          OPC_W'(OP_AND): ctl.alu_op = ALU_AND;
          OPC_W'(OP_OR):  ctl.alu_op = ALU_OR;
          default:        ctl.alu_op = ALU_PASS;
        endcase
        state_d = ST_F1_ADDR;
      end
      ST_EX_WR: begin ctl.mem_wr = 1'b1; state_d = ST_F1_ADDR; end
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_F1_ADDR;
    endcase
  end

  assign ctl_o    = ctl;
  assign halted_o = (state_q == ST_HALT);

  assert_strobe_excl_R2: assert property (@(negedge clk) disable iff (!rst_n)
    !(ctl.mem_rd && ctl.mem_wr));

  // R2: a read in the first fetch cycle is always followed by the buffer capture
  assert_fetch_capture_R2: assert property (@(negedge clk) disable iff (!rst_n)
    (state_q == ST_F1_RD) |=> ctl.mbr_from_mem);
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24,
  parameter int OPC_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_rd,
  output logic                    mem_wr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    halted,
  output logic [ADDR_W-1:0]       dbg_pc,
  output logic [ADDR_W-1:0]       dbg_sp,
  output logic [DATA_W-1:0]       dbg_ac,
  output logic [3:0]              dbg_flags,
  output logic [OPC_W+ADDR_W-1:0] dbg_ir
);
  // The instruction register is filled by exactly two data words.
  localparam int IR_W = OPC_W + ADDR_W;

  ctl_t               ctl;
  logic [ADDR_W-1:0]  pc_w, sp_w, mar_q;
  logic [DATA_W-1:0]  mbr_q, ac_q, alu_res;
  logic [IR_W-1:0]    ir_q;
  flags_t             flags_q, alu_flags;
  logic [OPC_W-1:0]   opcode;
  logic [ADDR_W-1:0]  ir_addr;

  assign opcode  = ir_q[IR_W-1 -: OPC_W];
  assign ir_addr = ir_q[ADDR_W-1:0];

  acc_ctrl_unit #(.OPC_W(OPC_W)) u_cu (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .flag_z_i(flags_q.z),
    .ctl_o(ctl), .halted_o(halted)
  );

  acc_pc_reg #(.W(ADDR_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .en_i(ctl.pc_en), .inc_sel_i(ctl.pc_inc),
    .load_i(ir_addr), .pc_o(pc_w)
  );

  acc_sp_reg #(.W(ADDR_W)) u_sp (
    .clk(clk), .rst_n(rst_n), .inc_i(ctl.sp_inc), .dec_i(ctl.sp_dec),
    .ld_i(ctl.sp_ld), .load_i(ir_addr), .sp_o(sp_w)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .a_i(ac_q), .b_i(mbr_q), .op_i(ctl.alu_op), .res_o(alu_res), .flags_o(alu_flags)
  );

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q   <= '0;
      mbr_q   <= '0;
      ir_q    <= '0;
      ac_q    <= '0;
      flags_q <= '0;
    end else begin
      if (ctl.mar_from_pc)      mar_q <= pc_w;
      else if (ctl.mar_from_ir) mar_q <= ir_addr;
      else if (ctl.mar_from_sp) mar_q <= sp_w;
      if (ctl.mbr_from_mem)     mbr_q <= mem_rdata;
      else if (ctl.mbr_from_ac) mbr_q <= ac_q;
      if (ctl.ir_hi_ld) ir_q[IR_W-1 -: DATA_W] <= mbr_q;
      if (ctl.ir_lo_ld) ir_q[DATA_W-1:0]       <= mbr_q;
      if (ctl.ac_ld) begin
        ac_q    <= alu_res;
        flags_q <= alu_flags;
      end
    end
  end

  assign mem_addr  = mar_q;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign mem_wdata = mbr_q;
  assign dbg_pc    = pc_w;
  assign dbg_sp    = sp_w;
  assign dbg_ac    = ac_q;
  assign dbg_flags = flags_q;
  assign dbg_ir    = ir_q;

  assert_wdata_is_ac_R6: assert property (@(negedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_wdata == ac_q));

  assert_zero_flag_R3: assert property (@(negedge clk) disable iff (!rst_n)
    ctl.ac_ld |=> (flags_q.z == (ac_q == '0)));

  assert_neg_flag_R5: assert property (@(negedge clk) disable iff (!rst_n)
    ctl.ac_ld |=> (flags_q.n == ac_q[DATA_W-1]));

  assert_halt_hold_R9: assert property (@(negedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_w) && !mem_rd && !mem_wr));
endmodule

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;
  localparam int CLK_HALF = 4; // 125 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        halted;
  logic [23:0] dbg_pc, dbg_sp;
  logic [15:0] dbg_ac;
  logic [3:0]  dbg_flags;
  logic [31:0] dbg_ir;

  int tests = 0;
  int fails = 0;
  int overlap_cnt = 0;
  int halt_strobe_cnt = 0;
  bit done = 1'b0;

  logic [15:0] mem  [256];
  logic [15:0] rmem [256];

  logic [23:0] ref_pc, ref_sp;
  logic [15:0] ref_ac;
  logic        ref_c, ref_v, ref_n, ref_z, ref_halt;

  always #(CLK_HALF) clk = ~clk;

  acc_cpu_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted), .dbg_pc(dbg_pc),
    .dbg_sp(dbg_sp), .dbg_ac(dbg_ac), .dbg_flags(dbg_flags), .dbg_ir(dbg_ir)
  );

  // memory model: one-cycle read latency, write on the same falling edge
  always @(negedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_rd && mem_wr) overlap_cnt++;
      if (halted && (mem_rd || mem_wr)) halt_strobe_cnt++;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic put_ins(input int at, input logic [7:0] op, input logic [23:0] a);
    mem[at]    = {op, a[23:16]};
    mem[at+1]  = a[15:0];
    rmem[at]   = {op, a[23:16]};
    rmem[at+1] = a[15:0];
  endtask

  task automatic put_dat(input int at, input logic [15:0] d);
    mem[at]  = d;
    rmem[at] = d;
  endtask

  task automatic set_nz();
    ref_n = ref_ac[15];
    ref_z = (ref_ac == 16'h0);
  endtask

  // behavioural interpreter: one whole instruction per call
  task automatic ref_step(output int len, output string tag);
    logic [15:0] hi, lo, m;
    logic [7:0]  op;
    logic [23:0] a;
    logic [16:0] s;
    hi = rmem[ref_pc[7:0]];
    lo = rmem[8'(ref_pc[7:0] + 8'd1)];
    op = hi[15:8];
    a  = {hi[7:0], lo};
    m  = rmem[a[7:0]];
    ref_pc = ref_pc + 24'd2;
    case (op)
      8'h00: begin ref_halt = 1'b1; len = 8; tag = "R9 R11"; end
      8'h01: begin ref_ac = m; set_nz(); ref_c = 0; ref_v = 0; len = 11; tag = "R3 R11"; end
      8'h02: begin rmem[a[7:0]] = ref_ac; len = 9; tag = "R6 R11"; end
      8'h03: begin
        s = {1'b0, ref_ac} + {1'b0, m};
        ref_v = (ref_ac[15] == m[15]) && (s[15] != ref_ac[15]);
        ref_c = s[16];
        ref_ac = s[15:0];
        set_nz();
        len = 11; tag = "R4 R11";
      end
      8'h04: begin ref_ac = ref_ac & m; set_nz(); ref_c = 0; ref_v = 0; len = 11; tag = "R5 R11"; end
      8'h05: begin ref_ac = ref_ac | m; set_nz(); ref_c = 0; ref_v = 0; len = 11; tag = "R5 R11"; end
      8'h06: begin ref_pc = a; len = 8; tag = "R7 R11"; end
      8'h07: begin if (ref_z) ref_pc = a; len = 8; tag = "R7 R11"; end
      8'h08: begin rmem[ref_sp[7:0]] = ref_ac; ref_sp = ref_sp - 24'd1; len = 9; tag = "R8 R11"; end
      8'h09: begin
        ref_sp = ref_sp + 24'd1;
        ref_ac = rmem[ref_sp[7:0]];
        set_nz(); ref_c = 0; ref_v = 0;
        len = 12; tag = "R8 R11";
      end
      8'h0A: begin ref_sp = a; len = 8; tag = "R8 R11"; end
      default: begin len = 8; tag = "R10 R11"; end
    endcase
  endtask

  task automatic cmp_state(input string tag);
    chk(tag, "pc", 32'(dbg_pc), 32'(ref_pc));
    chk(tag, "ac", 32'(dbg_ac), 32'(ref_ac));
    chk(tag, "flags", 32'(dbg_flags), 32'({ref_c, ref_v, ref_n, ref_z}));
    chk(tag, "sp", 32'(dbg_sp), 32'(ref_sp));
    chk(tag, "halted", 32'(halted), 32'(ref_halt));
  endtask

  initial begin
    int len;
    string tag;
    logic [23:0] pc_hold;
    for (int i = 0; i < 256; i++) begin mem[i] = '0; rmem[i] = '0; end
    put_dat(8'h40, 16'h7FFF);
    put_dat(8'h41, 16'h0001);
    put_dat(8'h42, 16'hF0F0);
    put_dat(8'h43, 16'h0FF0);
    put_dat(8'h44, 16'h8000);
    put_dat(8'h45, 16'h0000);
    put_ins(8'h00, 8'h01, 24'h40);   // load 7FFF
    put_ins(8'h02, 8'h03, 24'h41);   // add -> 8000, V N
    put_ins(8'h04, 8'h03, 24'h44);   // add -> 0000, C V Z
    put_ins(8'h06, 8'h07, 24'h0C);   // jz taken
    put_ins(8'h08, 8'h01, 24'h45);   // skipped
    put_ins(8'h0A, 8'h00, 24'h00);   // skipped halt
    put_ins(8'h0C, 8'h01, 24'h42);   // load F0F0
    put_ins(8'h0E, 8'h04, 24'h43);   // and -> 00F0
    put_ins(8'h10, 8'h05, 24'h44);   // or  -> 80F0
    put_ins(8'h12, 8'h02, 24'h50);   // store
    put_ins(8'h14, 8'h01, 24'h41);   // load 0001
    put_ins(8'h16, 8'h07, 24'h0A);   // jz not taken
    put_ins(8'h18, 8'h0A, 24'h80);   // sp <- 0x80
    put_ins(8'h1A, 8'h08, 24'h00);   // push 0001
    put_ins(8'h1C, 8'h01, 24'h50);   // load 80F0
    put_ins(8'h1E, 8'h08, 24'h00);   // push 80F0
    put_ins(8'h20, 8'h09, 24'h00);   // pop -> 80F0
    put_ins(8'h22, 8'h09, 24'h00);   // pop -> 0001
    put_ins(8'h24, 8'hEE, 24'h1234); // unknown: no-op
    put_ins(8'h26, 8'h06, 24'h2A);   // jump
    put_ins(8'h28, 8'h00, 24'h00);   // skipped halt
    put_ins(8'h2A, 8'h03, 24'h41);   // add -> 0002
    put_ins(8'h2C, 8'h00, 24'h00);   // halt

    ref_pc = '0; ref_sp = 24'hFFFFFF; ref_ac = '0;
    ref_c = 0; ref_v = 0; ref_n = 0; ref_z = 0; ref_halt = 0;

    repeat (3) @(posedge clk);
    // R1 reset state
    chk("R1", "pc", 32'(dbg_pc), 32'h0);
    chk("R1", "ac", 32'(dbg_ac), 32'h0);
    chk("R1", "flags", 32'(dbg_flags), 32'h0);
    chk("R1", "sp", 32'(dbg_sp), 32'hFFFFFF);
    chk("R1", "halted", 32'(halted), 32'h0);
    chk("R1", "strobes", 32'({mem_rd, mem_wr}), 32'h0);
    rst_n = 1'b1;

    for (int k = 0; k < 64 && !ref_halt; k++) begin
      ref_step(len, tag);
      if (k == 0) begin
        @(negedge clk); @(posedge clk);
        chk("R2", "first read strobe", 32'(mem_rd), 32'h1);
        chk("R2", "first read addr", 32'(mem_addr), 32'h0);
        chk("R12", "pc before falling edge", 32'(dbg_pc), 32'h0);
        @(negedge clk); #1;
        chk("R12", "pc after falling edge", 32'(dbg_pc), 32'h1);
        repeat (len - 2) @(negedge clk);
      end else begin
        repeat (len) @(negedge clk);
      end
      @(posedge clk);
      cmp_state(tag);
    end

    pc_hold = dbg_pc;
    repeat (20) @(negedge clk);
    @(posedge clk);
    chk("R9", "halted held", 32'(halted), 32'h1);
    chk("R9", "pc frozen", 32'(dbg_pc), 32'(pc_hold));
    chk("R9", "strobes while halted", 32'(halt_strobe_cnt), 32'h0);
    chk("R2", "rd/wr overlap cycles", 32'(overlap_cnt), 32'h0);
    chk("R6", "stored word", 32'(mem[8'h50]), 32'(rmem[8'h50]));
    chk("R6", "stored word value", 32'(mem[8'h50]), 32'h80F0);
    chk("R8", "first push slot", 32'(mem[8'h80]), 32'h0001);
    chk("R8", "second push slot", 32'(mem[8'h7F]), 32'h80F0);
    chk("R10", "final pc", 32'(dbg_pc), 32'h2E);
    chk("R4", "final ac", 32'(dbg_ac), 32'h0002);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(2 * CLK_HALF * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R11 watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule